// File: doc/BRIEF.md
# Register Transfer Unit for an 8/16-bit Accumulator CPU

This block executes the register-to-register move instructions of a CPU whose accumulator and index registers can each run 8 or 16 bits wide. Each request carries the current accumulator, both index registers, the stack pointer and the direct-page base, the two width-select bits, an emulation-mode bit and a 4-bit transfer code. The unit picks the source register, shapes the value to the width of the destination, works out the negative and zero flags, and presents the whole updated register set on registered outputs.

Requests enter through a valid/ready handshake and results leave through one. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the next edge with `out_valid` high. A result that has not been taken holds every output steady for as long as `out_ready` stays low. New requests are accepted only while the output stage is empty or is being drained in the same cycle, so back-pressure passes straight to the input with no extra buffering.

In emulation mode the stack pointer stays inside a fixed page, set by the `EMU_PAGE` parameter, and the reset state matches that mode.

Top module: `rtu_xfer_unit`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted request raises `out_valid` on the next edge. While `out_valid` is high and `out_ready` is low, `out_valid` and all register and flag outputs hold their values.
- R2: Transfer codes on `in_op` are: 0 A→X, 1 A→Y, 2 X→A, 3 Y→A, 4 X→Y, 5 Y→X, 6 X→S, 7 S→X, 8 A→S, 9 S→A, 10 A→D, 11 D→A. The source always supplies all 16 bits. Every register that is not the destination is output with the value it had at the input when the request was taken.
- R3: For codes 2 and 3 with `in_acc8`=1, only the low byte of A is replaced. The high byte keeps the incoming A high byte. With `in_acc8`=0, all 16 bits are written.
- R4: With `in_idx8`=1, a transfer into X or Y (codes 0, 1, 4, 5, 7) writes the source low byte and clears the high byte. With `in_idx8`=0, all 16 bits are written.
- R5: Codes 8, 9, 10 and 11 always move all 16 bits, whatever `in_acc8` is. Code 9 writes the whole stack pointer into A.
- R6: A transfer into S (codes 6 and 8) writes the source low byte and sets the high byte to `EMU_PAGE` when `in_emu`=1. When `in_emu`=0 it writes all 16 source bits.
- R7: `n_q` is the top bit of the written value at the destination width (bit 7 or bit 15). `z_q` is 1 when all bits of the written value at that width are 0. Transfers into S leave both flags unchanged.
- R8: Codes 12 to 15 change no register: all five outputs take their input values, and both flags keep their previous values.
- R9: After synchronous active-low reset, A, X, Y and D are 0, S is {`EMU_PAGE`, 8'h00}, and `n_q`, `z_q` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Transfer code |
| in_a | input | 16 | Current accumulator |
| in_x | input | 16 | Current X index |
| in_y | input | 16 | Current Y index |
| in_s | input | 16 | Current stack pointer |
| in_d | input | 16 | Current direct-page base |
| in_acc8 | input | 1 | Accumulator is 8 bits wide |
| in_idx8 | input | 1 | Index registers are 8 bits wide |
| in_emu | input | 1 | Emulation mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| a_q | output | 16 | Updated accumulator |
| x_q | output | 16 | Updated X |
| y_q | output | 16 | Updated Y |
| s_q | output | 16 | Updated stack pointer |
| d_q | output | 16 | Updated direct-page base |
| n_q | output | 1 | Negative flag |
| z_q | output | 1 | Zero flag |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, which gives 16-bit words, and `EMU_PAGE` = 8'h01. With these values the sign bits 7 and 15 and the all-zero byte and word cases all come up under random data. The emulation page also equals the reset high byte of S, so the reset state and the forced stack page can be checked against the same constant. Random `out_ready` gaps exercise stalls both before and after a result is taken.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

  typedef enum logic [2:0] {
    RID_A    = 3'd0,
    RID_X    = 3'd1,
    RID_Y    = 3'd2,
    RID_S    = 3'd3,
    RID_D    = 3'd4,
    RID_NONE = 3'd5
  } reg_id_e;

  localparam int NUM_REGS = 5;

  typedef enum logic [3:0] {
    OP_A2X = 4'd0,
    OP_A2Y = 4'd1,
    OP_X2A = 4'd2,
    OP_Y2A = 4'd3,
    OP_X2Y = 4'd4,
    OP_Y2X = 4'd5,
    OP_X2S = 4'd6,
    OP_S2X = 4'd7,
    OP_A2S = 4'd8,
    OP_S2A = 4'd9,
    OP_A2D = 4'd10,
    OP_D2A = 4'd11
  } op_e;

  typedef struct packed {
    reg_id_e src;
    reg_id_e dest;
    logic    fixed16;
  } ctl_t;

endpackage

// File: rtl/rtu_decode.sv
module rtu_decode
  import rtu_pkg::*;
(
  input  logic [3:0] op,
  output ctl_t       ctl
);

  always_comb begin
    ctl.src     = RID_A;
    ctl.dest    = RID_NONE;
    ctl.fixed16 = 1'b0;
    case (op)
      OP_A2X: begin ctl.src = RID_A; ctl.dest = RID_X; end
      OP_A2Y: begin ctl.src = RID_A; ctl.dest = RID_Y; end
      OP_X2A: begin ctl.src = RID_X; ctl.dest = RID_A; end
      OP_Y2A: begin ctl.src = RID_Y; ctl.dest = RID_A; end
      OP_X2Y: begin ctl.src = RID_X; ctl.dest = RID_Y; end
      OP_Y2X: begin ctl.src = RID_Y; ctl.dest = RID_X; end
      OP_X2S: begin ctl.src = RID_X; ctl.dest = RID_S; end
      OP_S2X: begin ctl.src = RID_S; ctl.dest = RID_X; end
      OP_A2S: begin ctl.src = RID_A; ctl.dest = RID_S; ctl.fixed16 = 1'b1; end
      OP_S2A: begin ctl.src = RID_S; ctl.dest = RID_A; ctl.fixed16 = 1'b1; end
      OP_A2D: begin ctl.src = RID_A; ctl.dest = RID_D; ctl.fixed16 = 1'b1; end
      OP_D2A: begin ctl.src = RID_D; ctl.dest = RID_A; ctl.fixed16 = 1'b1; end
      default: begin ctl.src = RID_A; ctl.dest = RID_NONE; end
    endcase
  end

endmodule

// File: rtl/rtu_shape.sv
module rtu_shape
  import rtu_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] EMU_PAGE = 8'h01,
  localparam int               WORD_W   = 2 * BYTE_W
) (
  input  reg_id_e           dest,
  input  logic              fixed16,
  input  logic [WORD_W-1:0] src_val,
  input  logic [WORD_W-1:0] acc_old,
  input  logic              acc8,
  input  logic              idx8,
  input  logic              emu,
  output logic [WORD_W-1:0] result,
  output logic              wide
);

  logic [BYTE_W-1:0] src_lo;
  assign src_lo = src_val[BYTE_W-1:0];

  always_comb begin
    result = src_val;
    wide   = 1'b1;
    case (dest)
      RID_A: begin
        if (acc8 && !fixed16) begin
          result = {acc_old[WORD_W-1:BYTE_W], src_lo};
          wide   = 1'b0;
        end
      end
      RID_X, RID_Y: begin
        if (idx8) begin
          result = {{BYTE_W{1'b0}}, src_lo};
          wide   = 1'b0;
        end
      end
      RID_S: begin
        if (emu) result = {EMU_PAGE, src_lo};
      end
      default: begin
        result = src_val;
      end
    endcase
  end

endmodule

// File: rtl/rtu_flags.sv
module rtu_flags #(
  parameter int  BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic [WORD_W-1:0] value,
  input  logic              wide,
  output logic              neg,
  output logic              zero
);

  always_comb begin
    if (wide) begin
      neg  = value[WORD_W-1];
      zero = (value == '0);
    end else begin
      neg  = value[BYTE_W-1];
      zero = (value[BYTE_W-1:0] == '0);
    end
  end

endmodule

// File: rtl/rtu_xfer_unit.sv
module rtu_xfer_unit
  import rtu_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] EMU_PAGE = 8'h01,
  localparam int               WORD_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_x,
  input  logic [WORD_W-1:0] in_y,
  input  logic [WORD_W-1:0] in_s,
  input  logic [WORD_W-1:0] in_d,
  input  logic              in_acc8,
  input  logic              in_idx8,
  input  logic              in_emu,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] a_q,
  output logic [WORD_W-1:0] x_q,
  output logic [WORD_W-1:0] y_q,
  output logic [WORD_W-1:0] s_q,
  output logic [WORD_W-1:0] d_q,
  output logic              n_q,
  output logic              z_q
);

  ctl_t              ctl;
  logic [WORD_W-1:0] cur   [NUM_REGS];
  logic [WORD_W-1:0] reg_q [NUM_REGS];
  logic [WORD_W-1:0] src_val;
  logic [WORD_W-1:0] result;
  logic              wide;
  logic              neg;
  logic              zero;
  logic              accept;
  logic              flag_wr;

  assign cur[RID_A] = in_a;
  assign cur[RID_X] = in_x;
  assign cur[RID_Y] = in_y;
  assign cur[RID_S] = in_s;
  assign cur[RID_D] = in_d;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  rtu_decode u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  assign src_val = cur[ctl.src];

  rtu_shape #(.BYTE_W(BYTE_W), .EMU_PAGE(EMU_PAGE)) u_shape (
    .dest    (ctl.dest),
    .fixed16 (ctl.fixed16),
    .src_val (src_val),
    .acc_old (in_a),
    .acc8    (in_acc8),
    .idx8    (in_idx8),
    .emu     (in_emu),
    .result  (result),
    .wide    (wide)
  );

  rtu_flags #(.BYTE_W(BYTE_W)) u_flags (
    .value (result),
    .wide  (wide),
    .neg   (neg),
    .zero  (zero)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
    localparam logic [WORD_W-1:0] RST_VAL =
      (i == int'(RID_S)) ? {EMU_PAGE, {BYTE_W{1'b0}}} : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        reg_q[i] <= RST_VAL;
      end else if (accept) begin
        reg_q[i] <= (ctl.dest == reg_id_e'(i)) ? result : cur[i];
      end
    end
  end

  assign flag_wr = accept && (ctl.dest != RID_S) && (ctl.dest != RID_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (flag_wr) begin
        n_q <= neg;
        z_q <= zero;
      end
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  assign a_q = reg_q[RID_A];
  assign x_q = reg_q[RID_X];
  assign y_q = reg_q[RID_Y];
  assign s_q = reg_q[RID_S];
  assign d_q = reg_q[RID_D];

endmodule

// File: rtl/rtu_xfer_chk.sv
module rtu_xfer_chk
  import rtu_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] EMU_PAGE = 8'h01,
  localparam int               WORD_W   = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic [WORD_W-1:0] in_s,
  input logic              in_idx8,
  input logic              in_emu,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] a_q,
  input logic [WORD_W-1:0] x_q,
  input logic [WORD_W-1:0] y_q,
  input logic [WORD_W-1:0] s_q,
  input logic [WORD_W-1:0] d_q,
  input logic              n_q,
  input logic              z_q
);

  logic armed;
  logic was_rst;
  logic take;
  logic to_stack;

  assign take     = in_valid && in_ready;
  assign to_stack = (in_op == OP_A2S) || (in_op == OP_X2S);

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
    was_rst <= !rst_n;
  end

  // R9: state seen one edge after a reset cycle
  always_ff @(posedge clk) begin
    if (was_rst && rst_n) begin
      a_r9_reset_state: assert (s_q == {EMU_PAGE, {BYTE_W{1'b0}}} && a_q == '0
                                && x_q == '0 && y_q == '0 && d_q == '0
                                && !n_q && !z_q && !out_valid);
    end
  end

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    out_valid && !out_ready |=> out_valid && $stable(a_q) && $stable(x_q)
      && $stable(y_q) && $stable(s_q) && $stable(d_q) && $stable(n_q) && $stable(z_q));

  a_r5_stack_to_acc: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    take && in_op == OP_S2A |=> a_q == $past(in_s));

  a_r6_emu_page: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    take && in_emu && to_stack |=> s_q[WORD_W-1:BYTE_W] == EMU_PAGE);

  a_r7_stack_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    take && to_stack |=> n_q == $past(n_q) && z_q == $past(z_q));

  a_r4_index_high_clear: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    take && in_idx8 && (in_op == OP_A2X || in_op == OP_Y2X || in_op == OP_S2X)
      |=> x_q[WORD_W-1:BYTE_W] == '0);

endmodule

bind rtu_xfer_unit rtu_xfer_chk #(.BYTE_W(BYTE_W), .EMU_PAGE(EMU_PAGE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_s      (in_s),
  .in_idx8   (in_idx8),
  .in_emu    (in_emu),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .a_q       (a_q),
  .x_q       (x_q),
  .y_q       (y_q),
  .s_q       (s_q),
  .d_q       (d_q),
  .n_q       (n_q),
  .z_q       (z_q)
);

// File: tb/sim_rtu_xfer_unit.sv
`timescale 1ns/1ps
module sim_rtu_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = 4'd0;
  logic [15:0] in_a = '0, in_x = '0, in_y = '0, in_s = '0, in_d = '0;
  logic        in_acc8 = 1'b0, in_idx8 = 1'b0, in_emu = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] a_q, x_q, y_q, s_q, d_q;
  logic        n_q, z_q;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rtu_xfer_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_x(in_x), .in_y(in_y), .in_s(in_s), .in_d(in_d),
    .in_acc8(in_acc8), .in_idx8(in_idx8), .in_emu(in_emu),
    .out_valid(out_valid), .out_ready(out_ready),
    .a_q(a_q), .x_q(x_q), .y_q(y_q), .s_q(s_q), .d_q(d_q), .n_q(n_q), .z_q(z_q)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] ma, mx, my, ms, md;
  logic        mn, mz, mv;

  task automatic model_apply();
    logic [15:0] r;
    bit upd;
    bit w;
    upd = 1; w = 1; r = '0;
    ma = in_a; mx = in_x; my = in_y; ms = in_s; md = in_d;
    case (in_op)
      0: begin mx = in_idx8 ? (in_a & 16'h00FF) : in_a; r = mx; w = !in_idx8; end
      1: begin my = in_idx8 ? (in_a & 16'h00FF) : in_a; r = my; w = !in_idx8; end
      2: begin ma = in_acc8 ? ((in_a & 16'hFF00) | (in_x & 16'h00FF)) : in_x; r = ma; w = !in_acc8; end
      3: begin ma = in_acc8 ? ((in_a & 16'hFF00) | (in_y & 16'h00FF)) : in_y; r = ma; w = !in_acc8; end
      4: begin my = in_idx8 ? (in_x & 16'h00FF) : in_x; r = my; w = !in_idx8; end
      5: begin mx = in_idx8 ? (in_y & 16'h00FF) : in_y; r = mx; w = !in_idx8; end
      6: begin ms = in_emu ? (16'h0100 | (in_x & 16'h00FF)) : in_x; upd = 0; end
      7: begin mx = in_idx8 ? (in_s & 16'h00FF) : in_s; r = mx; w = !in_idx8; end
      8: begin ms = in_emu ? (16'h0100 | (in_a & 16'h00FF)) : in_a; upd = 0; end
      9: begin ma = in_s; r = ma; end
      10: begin md = in_a; r = md; end
      11: begin ma = in_d; r = ma; end
      default: upd = 0;
    endcase
    if (upd) begin
      mn = w ? r[15] : r[7];
      mz = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ma = 0; mx = 0; my = 0; md = 0; ms = 16'h0100; mn = 0; mz = 0; mv = 0;
    end else begin
      bit acc;
      acc = in_valid && (!mv || out_ready);
      if (acc) model_apply();
      mv = acc ? 1'b1 : (out_ready ? 1'b0 : mv);
    end
  end

  bit compare_on = 0;
  always @(posedge clk) begin
    #2;
    if (compare_on) begin
      check("R2", "model a_q", a_q, ma);
      check("R4", "model x_q", x_q, mx);
      check("R4", "model y_q", y_q, my);
      check("R6", "model s_q", s_q, ms);
      check("R5", "model d_q", d_q, md);
      check("R7", "model n_q", {15'd0, n_q}, {15'd0, mn});
      check("R7", "model z_q", {15'd0, z_q}, {15'd0, mz});
      check("R1", "model out_valid", {15'd0, out_valid}, {15'd0, mv});
      check("R1", "model in_ready", {15'd0, in_ready}, {15'd0, !mv || out_ready});
    end
  end

  task automatic send(input logic [3:0] op, input logic [15:0] a, x, y, s, d,
                      input logic acc8, idx8, emu);
    @(negedge clk);
    in_op = op; in_a = a; in_x = x; in_y = y; in_s = s; in_d = d;
    in_acc8 = acc8; in_idx8 = idx8; in_emu = emu; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "reset s_q", s_q, 16'h0100);
    check("R9", "reset a_q", a_q, 16'h0000);
    check("R9", "reset flags/valid", {13'd0, n_q, z_q, out_valid}, 16'h0);
    compare_on = 1;

    send(4'd2, 16'h1234, 16'h0080, 16'h5555, 16'h01F0, 16'h2000, 1'b1, 1'b0, 1'b0);
    check("R3", "A low-byte write", a_q, 16'h1280);
    check("R7", "N after 8-bit A", {15'd0, n_q}, 16'd1);
    check("R2", "Y passes through", y_q, 16'h5555);

    send(4'd0, 16'hAB00, 16'h7777, 16'h0001, 16'h01F0, 16'h2000, 1'b0, 1'b1, 1'b0);
    check("R4", "X high cleared", x_q, 16'h0000);
    check("R7", "Z after 8-bit X", {15'd0, z_q}, 16'd1);

    send(4'd9, 16'h0000, 16'h0, 16'h0, 16'h01FF, 16'h0, 1'b1, 1'b1, 1'b1);
    check("R5", "S to A full word", a_q, 16'h01FF);
    check("R7", "flags 16-bit", {14'd0, n_q, z_q}, 16'h0);

    send(4'd8, 16'hBEEF, 16'h0, 16'h0, 16'h01FF, 16'h0, 1'b1, 1'b1, 1'b1);
    check("R6", "emu A to S", s_q, 16'h01EF);
    check("R7", "stack keeps flags", {14'd0, n_q, z_q}, 16'h0);

    send(4'd8, 16'hBEEF, 16'h0, 16'h0, 16'h01FF, 16'h0, 1'b1, 1'b1, 1'b0);
    check("R6", "native A to S", s_q, 16'hBEEF);

    send(4'd6, 16'h0, 16'h7722, 16'h0, 16'hFFFF, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R6", "emu X to S", s_q, 16'h0122);

    send(4'd11, 16'h00FF, 16'h0, 16'h0, 16'h0100, 16'h8000, 1'b1, 1'b0, 1'b0);
    check("R5", "D to A ignores acc8", a_q, 16'h8000);
    check("R7", "N bit 15", {15'd0, n_q}, 16'd1);

    send(4'd13, 16'h0000, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 1'b0, 1'b0, 1'b0);
    check("R8", "reserved code a_q", a_q, 16'h0000);
    check("R8", "reserved code d_q", d_q, 16'h4444);
    check("R8", "reserved keeps N", {15'd0, n_q}, 16'd1);

    // R1: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd10; in_a = 16'h9999; in_valid = 1'b1;
    @(negedge clk);
    check("R1", "stalled out_valid", {15'd0, out_valid}, 16'd1);
    check("R1", "stalled in_ready", {15'd0, in_ready}, 16'd0);
    check("R1", "stalled d_q", d_q, 16'h9999);
    in_a = 16'h6666;
    @(negedge clk);
    check("R1", "d_q held", d_q, 16'h9999);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "taken after release", d_q, 16'h6666);

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      in_op    = 4'($urandom % 16);
      in_a     = 16'($urandom);
      in_x     = 16'($urandom);
      in_y     = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      in_s     = 16'($urandom);
      in_d     = ($urandom % 4 == 0) ? 16'h0080 : 16'($urandom);
      in_acc8  = 1'($urandom);
      in_idx8  = 1'($urandom);
      in_emu   = 1'($urandom);
      in_valid = ($urandom % 4 != 0);
      out_ready = ($urandom % 3 != 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule